// File: doc/BRIEF.md
# Status-code I2C master

This block is an I2C bus master that software controls through a few byte-wide registers on a simple processor bus. It sits between a register port and two open-drain lines. For each line it drives an output enable, which pulls the wire low when set, and SDA also has an input. Software asks for one bus phase at a time: a START or repeated START, one byte out or in, or a STOP. The block runs that phase, then raises an event flag and freezes with SCL held low. It also publishes a one-byte status code that tells software what happened, so software can decide the next phase.

Register addresses are: 0 data, 1 control, 2 status (read), 3 clock divider, 4 soft reset (write). Control bits are: 2 acknowledge-enable, 3 event flag, 4 STOP request, 5 START request, 6 enable, 7 interrupt enable. One parameter, `FLAG_W1C`, chooses how software clears the event flag. The block is master-only. It has no arbitration and does not handle a slave stretching the clock.

Top module: `i2c_phase_master`

## Requirements
- R1: After reset, status (address 2) reads 0xF8, control (address 1) reads 0x00, both line enables are released and `irq` is low.
- R2: With enable (control bit 6) set, a START request (bit 5) from idle produces a START condition, sets the event flag (bit 3) and gives status 0x08. A START request made while an event is pending gives status 0x10. In both cases the START bit reads back 0 once the condition has been issued.
- R3: While the event flag is set, SCL stays driven low and the status code does not change.
- R4: The byte sent right after a START is the address, and its bit 0 selects the direction (1 = read). The result status is 0x18 for write+ACK, 0x20 for write+NACK, 0x40 for read+ACK and 0x48 for read+NACK.
- R5: In write direction each data byte gives status 0x28 when the slave ACKs and 0x30 when it NACKs, and the byte appears on SDA MSB first.
- R6: In read direction control bit 2 chooses whether the master ACKs the received byte. The status is 0x50 when it ACKs and 0x58 when it does not, and the byte reads back from address 0.
- R7: With `FLAG_W1C`=1, writing control with bit 3 = 1 clears the flag and starts the next phase, while bit 3 = 0 leaves it pending. With `FLAG_W1C`=0 the two values swap roles.
- R8: Clearing the flag with the STOP request (bit 4) set produces a STOP condition. No flag is raised afterwards, status returns to 0xF8, both lines are released and the STOP bit reads 0.
- R9: One SCL period lasts 10·(M+1)·2^N clock cycles. M is the divider register's bits [6:3] and N is its bits [2:0].
- R10: A write to the data register is ignored unless the event flag is set.
- R11: `irq` is high exactly when the event flag and control bit 7 are both set.
- R12: Writing control with bit 6 = 0 aborts any transfer. The next cycle both lines are released, the flag is clear and status reads 0xF8.
- R13: Any write to address 4 returns every register, including the divider, to its reset value and returns the engine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Access is a write |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Event interrupt |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The bench builds the block with `FLAG_W1C`=1, so the write-one clear and the case where a zero write leaves the flag pending are both exercised. It programs the divider first with M=1, N=1, giving a 40-cycle SCL period. It then reprograms it with M=0, N=0, the fastest 10-cycle case, and measures both periods. A behavioural slave on the wired-AND bus ACKs one address and can NACK data. This brings every status code into reach: write, read, repeated START and address NACK.

// File: rtl/i2c_phase_master.sv
module i2c_phase_master #(
  parameter bit FLAG_W1C = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam logic [2:0] A_DATA = 3'd0, A_CTRL = 3'd1, A_STAT = 3'd2, A_BAUD = 3'd3, A_SRST = 3'd4;
  localparam int DIV_W = 11;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_WAIT, S_STOP} st_t;
  st_t st;

  logic ack_en, stop_rq, start_rq, en, ie, iflg;
  logic [7:0] code, shreg;
  logic [3:0] bm, slot, bitcnt;
  logic [2:0] bn;
  logic [DIV_W-1:0] divcnt;
  logic addr_ph, rd_mode, sda_drv, rep, ack_in;

  wire wr_any  = reg_sel && reg_wr;
  wire wr_ctrl = wr_any && reg_addr == A_CTRL;
  wire srst    = wr_any && reg_addr == A_SRST;
  wire clr_req = wr_ctrl && (FLAG_W1C ? reg_wdata[3] : !reg_wdata[3]);
  wire running = st == S_START || st == S_BIT || st == S_STOP;
  wire [DIV_W-1:0] div_lim = (({7'd0, bm} + 11'd1) << bn) - 11'd1;
  wire tick = running && divcnt == div_lim;
  wire last = tick && slot == 4'd9;
  wire tx   = addr_ph || !rd_mode;
  wire [7:0] status = iflg ? code : 8'hF8;

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      st <= S_IDLE; ack_en <= 0; stop_rq <= 0; start_rq <= 0; en <= 0; ie <= 0; iflg <= 0;
      code <= 8'hF8; shreg <= 0; bm <= 0; bn <= 0; slot <= 0; bitcnt <= 0; divcnt <= 0;
      addr_ph <= 0; rd_mode <= 0; sda_drv <= 0; rep <= 0; ack_in <= 0;
    end else begin
      if (!running) begin divcnt <= 0; slot <= 0; end
      else if (tick) begin divcnt <= 0; slot <= (slot == 4'd9) ? 4'd0 : slot + 4'd1; end
      else divcnt <= divcnt + 1'b1;

      if (wr_ctrl) begin
        ack_en <= reg_wdata[2]; stop_rq <= reg_wdata[4]; start_rq <= reg_wdata[5];
        en <= reg_wdata[6]; ie <= reg_wdata[7];
      end
      if (wr_any && reg_addr == A_BAUD) begin bm <= reg_wdata[6:3]; bn <= reg_wdata[2:0]; end
      if (wr_any && reg_addr == A_DATA && iflg) shreg <= reg_wdata;

      case (st)
        S_IDLE: if (en && start_rq) begin st <= S_START; rep <= 0; end
        S_START: if (last) begin
          st <= S_WAIT; iflg <= 1; code <= rep ? 8'h10 : 8'h08;
          start_rq <= 0; addr_ph <= 1; sda_drv <= 1;
        end
        S_BIT: begin
          if (tick && slot == 4'd1)
            sda_drv <= (bitcnt < 4'd8) ? (tx && !shreg[7]) : (!tx && ack_en);
          if (tick && slot == 4'd7) begin
            if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_in};
            else ack_in <= !sda_in;
          end
          if (last) begin
            if (bitcnt == 4'd8) begin
              st <= S_WAIT; iflg <= 1; addr_ph <= 0;
              if (addr_ph) rd_mode <= shreg[0];
              code <= addr_ph ? (shreg[0] ? (ack_in ? 8'h40 : 8'h48) : (ack_in ? 8'h18 : 8'h20))
                    : (rd_mode ? (ack_in ? 8'h50 : 8'h58) : (ack_in ? 8'h28 : 8'h30));
            end else bitcnt <= bitcnt + 4'd1;
          end
        end
        S_WAIT: if (clr_req) begin
          iflg <= 0;
          if (reg_wdata[5]) begin st <= S_START; rep <= 1; end
          else if (reg_wdata[4]) st <= S_STOP;
          else begin st <= S_BIT; bitcnt <= 0; end
        end
        S_STOP: if (last) begin st <= S_IDLE; stop_rq <= 0; sda_drv <= 0; end
        default: st <= S_IDLE;
      endcase

      if (wr_ctrl && !reg_wdata[6]) begin st <= S_IDLE; iflg <= 0; sda_drv <= 0; end
    end
  end

  assign scl_oe = st == S_WAIT || ((st == S_BIT || st == S_STOP || (st == S_START && rep)) && slot < 4'd5);
  assign sda_oe = (st == S_START) ? slot >= 4'd7 :
                  (st == S_STOP)  ? slot < 4'd7  :
                  (st == S_BIT || st == S_WAIT) ? sda_drv : 1'b0;
  assign irq = iflg && ie;

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = shreg;
      A_CTRL:  reg_rdata = {ie, en, start_rq, stop_rq, iflg, ack_en, 2'b00};
      A_STAT:  reg_rdata = status;
      A_BAUD:  reg_rdata = {1'b0, bm, bn};
      default: reg_rdata = 8'h00;
    endcase
  end

  assert_hold_scl_R3: assert property (@(posedge clk) disable iff (!rst_n) iflg |-> scl_oe);
  assert_code_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflg) |-> (code == 8'h08 || code == 8'h10 || code == 8'h18 || code == 8'h20 ||
                     code == 8'h28 || code == 8'h30 || code == 8'h40 || code == 8'h48 ||
                     code == 8'h50 || code == 8'h58));
  assert_stop_noflag_R8: assert property (@(posedge clk) disable iff (!rst_n) (st == S_STOP) |=> !iflg);
  assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !reg_wdata[6]) |=> (!scl_oe && !sda_oe && !irq));
  assert_data_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && reg_addr == A_DATA && st == S_IDLE) |=> $stable(shreg));
endmodule

// File: tb/i2c_phase_master_bench.sv
`timescale 1ns/1ps
module i2c_phase_master_bench;
  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic s_low = 0;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || s_low);
  int checks = 0, fails = 0;
  int cyc = 0, last_rise = 0, per = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  i2c_phase_master #(.FLAG_W1C(1'b1)) u_i2c_phase_master (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda));

  // behavioural slave at address 0x2A
  int k = 0, ri = 0;
  bit s_addr = 0, s_rd = 0, s_match = 0, mack = 0, nack_data = 0;
  logic [7:0] rxb = 0, txb = 0, last_rx = 0;
  logic [7:0] rbytes [2];
  initial begin rbytes[0] = 8'h9B; rbytes[1] = 8'h47; end

  always @(negedge sda) if (scl === 1'b1) begin k = 0; s_addr = 1; s_low = 0; end
  always @(posedge scl) begin
    per = cyc - last_rise; last_rise = cyc;
    k = k + 1;
    if (k <= 8) rxb = {rxb[6:0], sda}; else mack = !sda;
  end
  always @(negedge scl) begin
    if (k == 8) begin
      if (s_addr) begin s_match = (rxb[7:1] == 7'h2A); s_low = s_match; end
      else if (!s_rd) begin last_rx = rxb; s_low = !nack_data; end
      else s_low = 0;
    end else if (k == 9) begin
      k = 0; s_low = 0;
      if (s_addr) begin
        s_addr = 0; s_rd = rxb[0];
        if (s_rd && s_match && ri < 2) begin txb = rbytes[ri]; ri++; s_low = !txb[7]; end
      end else if (s_rd && mack && ri < 2) begin txb = rbytes[ri]; ri++; s_low = !txb[7]; end
    end else if (k >= 1 && k <= 7 && s_rd && !s_addr && s_match) s_low = !txb[7-k];
  end

  // per-clock model comparison: a pending interrupt event must hold SCL low (R3)
  always @(negedge clk) if (rst_n && irq) begin
    checks++;
    if (!scl_oe) begin fails++; $display("FAIL R3 scl_oe actual=%0d expected=1", scl_oe); end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_sel = 0; reg_wr = 0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask
  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    if (!irq) begin checks++; fails++; $display("FAIL %s irq actual=0 expected=1", tag); end
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(4); rst_n = 1; idle(2);
    rd(2, v); chk("R1 status", v, 8'hF8);
    rd(1, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 lines", {scl_oe, sda_oe, irq}, 3'b000);

    wr(3, 8'h09);                 // M=1 N=1
    wr(1, 8'hC0); wr(1, 8'hE0);
    wait_irq("R2"); rd(2, v); chk("R2 start code", v, 8'h08);
    rd(1, v); chk("R2 start self-clear", v, 8'hC8);
    idle(100); rd(2, v); chk("R3 status stable", v, 8'h08);
    chk("R3 scl held", scl_oe, 1);
    wr(0, 8'h54); wr(1, 8'hC8);   // address 0x2A write
    idle(5); wait_irq("R4"); rd(2, v); chk("R4 addr write ack", v, 8'h18);
    chk("R9 period 40", per, 40);
    wr(0, 8'hA5); wr(1, 8'hC8);
    idle(5); wait_irq("R5"); rd(2, v); chk("R5 data ack", v, 8'h28);
    chk("R5 slave byte", last_rx, 8'hA5);
    nack_data = 1;
    wr(0, 8'h3C); wr(1, 8'hC8);
    idle(5); wait_irq("R5"); rd(2, v); chk("R5 data nack", v, 8'h30);
    nack_data = 0;
    wr(1, 8'hE8);
    idle(5); wait_irq("R2"); rd(2, v); chk("R2 repeated start", v, 8'h10);
    rd(1, v); chk("R2 rep self-clear", v, 8'hC8);
    wr(0, 8'h55); wr(1, 8'hC8);
    idle(5); wait_irq("R4"); rd(2, v); chk("R4 addr read ack", v, 8'h40);
    wr(1, 8'hCC);
    idle(5); wait_irq("R6"); rd(2, v); chk("R6 read ack", v, 8'h50);
    rd(0, v); chk("R6 byte0", v, 8'h9B);
    wr(1, 8'hC8);
    idle(5); wait_irq("R6"); rd(2, v); chk("R6 read nack", v, 8'h58);
    rd(0, v); chk("R6 byte1", v, 8'h47);
    wr(1, 8'hD8);
    idle(150);
    chk("R8 no flag", irq, 0);
    rd(2, v); chk("R8 status", v, 8'hF8);
    chk("R8 lines", {scl_oe, sda_oe}, 2'b00);
    rd(1, v); chk("R8 stop self-clear", v, 8'hC0);
    wr(0, 8'h11); rd(0, v); chk("R10 data ignored", v, 8'h47);

    wr(3, 8'h00);                 // M=0 N=0
    wr(1, 8'hE0);
    idle(2); wait_irq("R2"); rd(2, v); chk("R2 start code 2", v, 8'h08);
    wr(0, 8'h62); wr(1, 8'hC8);
    idle(5); wait_irq("R4"); rd(2, v); chk("R4 addr nack", v, 8'h20);
    chk("R9 period 10", per, 10);
    wr(1, 8'hC0); idle(60);
    chk("R7 zero keeps flag", irq, 1);
    rd(2, v); chk("R7 status kept", v, 8'h20);
    wr(1, 8'h40); idle(2);
    chk("R11 irq masked", irq, 0);
    rd(1, v); chk("R11 flag still set", v, 8'h48);
    wr(1, 8'hC0); idle(2);
    chk("R11 irq unmasked", irq, 1);
    wr(1, 8'h00);
    chk("R12 lines", {scl_oe, sda_oe, irq}, 3'b000);
    rd(2, v); chk("R12 status", v, 8'hF8);

    wr(3, 8'h09); wr(1, 8'hC0); wr(1, 8'hE0);
    wait_irq("R13"); rd(2, v); chk("R13 pre", v, 8'h08);
    wr(4, 8'h00);
    rd(2, v); chk("R13 status", v, 8'hF8);
    rd(1, v); chk("R13 ctrl", v, 8'h00);
    rd(3, v); chk("R13 baud", v, 8'h00);
    chk("R13 lines", {scl_oe, sda_oe, irq}, 3'b000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule